// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block switches up to seven power domains on and off under software control over a simple 32-bit register bus. Software first loads a one-hot or multi-hot selection into a power-up or a power-down selection register. It then writes a three-byte unlock sequence to a single command register: a reset byte, followed by a two-byte code that belongs to the direction. A small parser checks each byte as it arrives. Only a complete and correct sequence starts a transition.

Each selected domain that is not already in the requested state gets its own countdown timer, which models the latency of the switch. The domain's bit in the live power-state register flips when its timer expires. Once every selected domain has settled, a sequence-done event is recorded. Protocol errors are recorded as software failures and leave every domain as it was. Events are kept in two write-one-to-clear registers. The interrupt status register is filtered through a mask register to produce a single level-sensitive interrupt line, which stays high until software clears the cause.

The latency parameter `LAT` must be at least 1 and must stay well inside a 100 µs budget at the operating clock.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset the power-state register (offset 0x80) reads 0x03 (domains 0 and 1 on), interrupt status (0x8C) and event status (0x88) read 0, the interrupt mask (0x48) reads 0x1FF, and `irq` is low.
- R2: Power-up is started by the command bytes 0xFF, 0x05, 0x50 written in that order to offset 0x44, using bits 7:0 of the write data. Each domain set in the power-up selection (0x0C) and currently off turns on exactly LAT clock cycles after the clock edge that captures 0x50.
- R3: Power-down is started by the command bytes 0xFF, 0x0A, 0xA0. Each domain set in the power-down selection (0x10) and currently on turns off LAT cycles after the edge that captures 0xA0. Domains whose selection bit is 0 are unchanged in both directions.
- R4: A command byte that is neither 0xFF nor the next expected code sets bit 2 of both status registers and returns the parser to its start state. This includes any byte other than 0xFF in the start state. No domain changes as a result.
- R5: A 0xFF byte restarts the parser from any state without flagging a failure.
- R6: Sequence-done (bit 0 of both status registers) is set one cycle after the last selected domain flips. If no selected domain needs to change, it is set on the edge after the unlock byte is captured.
- R7: A valid unlock that completes while a transition is still running sets bit 3 of both status registers and does not change the running transition or any domain.
- R8: `irq` is high when any bit of interrupt status is 1 and the matching mask bit is 0. It stays high until that cause is cleared or masked.
- R9: Writing 1s to 0x8C or 0x88 clears the matching bits of that register only. If a new event is set in the same cycle as its bit is cleared, the event wins and the bit stays 1.
- R10: The selection registers read back bits 6:0, the mask reads back bits 8:0, and the command register and unmapped offsets read 0. Selection bits above bit 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe, one write per cycle |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| domPwr | output | 7 | Live power state, one bit per domain |
| irq | output | 1 | Level interrupt, unmasked status present |

## Verification
Two events can coincide: a status bit can be set and cleared by software in the same cycle. The bench provokes this with an unlock for a domain that is already in the requested state, which raises sequence-done on the very next edge. The write-one-to-clear of bit 0 is issued back to back with that unlock byte, so it lands on that same edge. The bit must read 1 afterwards, while the event register, which was not written, independently also holds its bit. A second overlap, an unlock arriving while a transition is still counting down, is judged by the busy-reject bit and by the power state that the first transition alone produces.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int ADDR_W = 8;
  localparam int STAT_W = 9;

  localparam logic [ADDR_W-1:0] OFS_UP_SEL   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DN_SEL   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CMD      = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_IRQ_MASK = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_PWR      = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_EVT      = 8'h88;
  localparam logic [ADDR_W-1:0] OFS_IRQ_STAT = 8'h8C;

  localparam logic [7:0] CODE_RESTART = 8'hFF;
  localparam logic [7:0] CODE_UP_A    = 8'h05;
  localparam logic [7:0] CODE_UP_B    = 8'h50;
  localparam logic [7:0] CODE_DN_A    = 8'h0A;
  localparam logic [7:0] CODE_DN_B    = 8'hA0;

  localparam int BIT_DONE      = 0;
  localparam int BIT_CMD_FAIL  = 2;
  localparam int BIT_BUSY_FAIL = 3;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_ARMED = 2'd1,
    PS_UP1   = 2'd2,
    PS_DN1   = 2'd3
  } parse_state_e;

  typedef struct packed {
    logic wrUpSel;
    logic wrDnSel;
    logic wrMask;
    logic clrStat;
    logic clrEvt;
    logic startUp;
    logic startDown;
    logic parseFail;
    logic busyFail;
  } ctrl_strobe_t;

endpackage

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [7:0]          cmdByte,
  input  logic                busy,
  output ctrl_strobe_t        strb
);

  parse_state_e parseState, parseNext;
  logic cmdWrite;

  assign cmdWrite = busWrite && (busAddr == OFS_CMD);

  always_comb begin
    parseNext      = parseState;
    strb           = '0;
    strb.wrUpSel   = busWrite && (busAddr == OFS_UP_SEL);
    strb.wrDnSel   = busWrite && (busAddr == OFS_DN_SEL);
    strb.wrMask    = busWrite && (busAddr == OFS_IRQ_MASK);
    strb.clrStat   = busWrite && (busAddr == OFS_IRQ_STAT);
    strb.clrEvt    = busWrite && (busAddr == OFS_EVT);
    if (cmdWrite) begin
      if (cmdByte == CODE_RESTART) begin
        parseNext = PS_ARMED;
      end else begin
        parseNext = PS_IDLE;
        unique case (parseState)
          PS_ARMED: begin
            if (cmdByte == CODE_UP_A)      parseNext = PS_UP1;
            else if (cmdByte == CODE_DN_A) parseNext = PS_DN1;
            else                           strb.parseFail = 1'b1;
          end
          PS_UP1: begin
            if (cmdByte == CODE_UP_B) begin
              if (busy) strb.busyFail = 1'b1;
              else      strb.startUp  = 1'b1;
            end else begin
              strb.parseFail = 1'b1;
            end
          end
          PS_DN1: begin
            if (cmdByte == CODE_DN_B) begin
              if (busy) strb.busyFail  = 1'b1;
              else      strb.startDown = 1'b1;
            end else begin
              strb.parseFail = 1'b1;
            end
          end
          default: strb.parseFail = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) parseState <= PS_IDLE;
    else       parseState <= parseNext;
  end

  AST_ONE_CMD_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.startUp, strb.startDown, strb.parseFail, strb.busyFail})); // R4

  AST_RESTART_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && cmdByte == CODE_RESTART) |=> (parseState == PS_ARMED)); // R5

  AST_FAIL_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.parseFail |=> (parseState == PS_IDLE)); // R4

endmodule

// File: rtl/pwr_seq_dpath.sv
module pwr_seq_dpath
  import pwr_seq_pkg::*;
#(
  parameter int                 NUM_DOM   = 7,
  parameter int                 LAT       = 50,
  parameter logic [NUM_DOM-1:0] RESET_PWR = 7'b0000011
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strb,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic [NUM_DOM-1:0]  domPwr,
  output logic                busy,
  output logic                irq
);

  localparam int CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] LAT_LOAD = CNT_W'(LAT);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [NUM_DOM-1:0] upSel, dnSel, power, changeSel, flipNow, running;
  logic [STAT_W-1:0]  irqMask, irqStat, evtStat, setVec, clrStatVec, clrEvtVec;
  logic               startAny, doneNow;
  logic [CNT_W-1:0]   domCnt [NUM_DOM];

  assign startAny  = strb.startUp || strb.startDown;
  assign changeSel = strb.startUp   ? (upSel & ~power) :
                     strb.startDown ? (dnSel &  power) : '0;

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               domCnt[d] <= '0;
        else if (changeSel[d])   domCnt[d] <= LAT_LOAD;
        else if (domCnt[d] != 0) domCnt[d] <= domCnt[d] - CNT_ONE;
      end
      assign running[d] = (domCnt[d] != 0);
      assign flipNow[d] = (domCnt[d] == CNT_ONE);
    end
  endgenerate

  assign doneNow = busy && !(|running);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      power <= RESET_PWR;
    end else begin
      power <= power ^ flipNow;
      if (startAny)     busy <= 1'b1;
      else if (doneNow) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upSel   <= '0;
      dnSel   <= '0;
      irqMask <= '1;
    end else begin
      if (strb.wrUpSel) upSel   <= busWdata[NUM_DOM-1:0];
      if (strb.wrDnSel) dnSel   <= busWdata[NUM_DOM-1:0];
      if (strb.wrMask)  irqMask <= busWdata[STAT_W-1:0];
    end
  end

  always_comb begin
    setVec                = '0;
    setVec[BIT_DONE]      = doneNow;
    setVec[BIT_CMD_FAIL]  = strb.parseFail;
    setVec[BIT_BUSY_FAIL] = strb.busyFail;
  end

  assign clrStatVec = strb.clrStat ? busWdata[STAT_W-1:0] : '0;
  assign clrEvtVec  = strb.clrEvt  ? busWdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqStat <= '0;
      evtStat <= '0;
    end else begin
      irqStat <= (irqStat & ~clrStatVec) | setVec;
      evtStat <= (evtStat & ~clrEvtVec)  | setVec;
    end
  end

  assign irq    = |(irqStat & ~irqMask);
  assign domPwr = power;

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      OFS_UP_SEL:   busRdata[NUM_DOM-1:0] = upSel;
      OFS_DN_SEL:   busRdata[NUM_DOM-1:0] = dnSel;
      OFS_IRQ_MASK: busRdata[STAT_W-1:0]  = irqMask;
      OFS_PWR:      busRdata[NUM_DOM-1:0] = power;
      OFS_EVT:      busRdata[STAT_W-1:0]  = evtStat;
      OFS_IRQ_STAT: busRdata[STAT_W-1:0]  = irqStat;
      default:      busRdata = '0;
    endcase
  end

  AST_POWER_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(power)); // R4

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startAny |=> busy); // R2

  AST_REJECT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.busyFail |-> busy); // R7

  AST_DONE_IN_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStat[BIT_DONE]) |-> evtStat[BIT_DONE]); // R6

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !strb.clrStat && !strb.wrMask) |=> irq); // R8

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int                 NUM_DOM   = 7,
  parameter int                 LAT       = 50,
  parameter logic [NUM_DOM-1:0] RESET_PWR = 7'b0000011
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrite,
  input  logic [7:0]          busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic [NUM_DOM-1:0]  domPwr,
  output logic                irq
);

  ctrl_strobe_t strb;
  logic         busy;

  pwr_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .cmdByte (busWdata[7:0]),
    .busy    (busy),
    .strb    (strb)
  );

  pwr_seq_dpath #(
    .NUM_DOM  (NUM_DOM),
    .LAT      (LAT),
    .RESET_PWR(RESET_PWR)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .domPwr  (domPwr),
    .busy    (busy),
    .irq     (irq)
  );

endmodule

// File: tb/pwr_seq_top_tb.sv
`timescale 1ns/1ps
module pwr_seq_top_tb;

  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [6:0]  domPwr;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  logic [6:0] expPwr;

  always #5 clk = ~clk;

  pwr_seq_top #(.NUM_DOM(7), .LAT(LAT), .RESET_PWR(7'b0000011)) u_dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .domPwr(domPwr), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write is captured on the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic seqUp();
    wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'h50);
  endtask

  task automatic seqDn();
    wr(8'h44, 32'hFF); wr(8'h44, 32'h0A); wr(8'h44, 32'hA0);
  endtask

  task automatic clearAll();
    wr(8'h8C, 32'h1FF); wr(8'h88, 32'h1FF);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    rd(8'h80, v); check("R1 power", v, 32'h03);
    rd(8'h8C, v); check("R1 irqStat", v, 32'h0);
    rd(8'h88, v); check("R1 evtStat", v, 32'h0);
    rd(8'h48, v); check("R1 mask", v, 32'h1FF);
    check("R1 irq", {31'b0, irq}, 32'h0);
    expPwr = 7'h03;

    // R10 readback and width
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); check("R10 upSel", v, 32'h7F);
    wr(8'h10, 32'h0000_0155); rd(8'h10, v); check("R10 dnSel", v, 32'h55);
    wr(8'h48, 32'hFFFF_FE00); rd(8'h48, v); check("R10 mask", v, 32'h0);
    wr(8'h48, 32'h1FF);
    rd(8'h44, v); check("R10 cmd reads 0", v, 32'h0);
    rd(8'h20, v); check("R10 unmapped", v, 32'h0);

    // R2 exact latency, domain 2 on
    wr(8'h0C, 32'h04);
    seqUp();
    tick(LAT - 1);
    check("R2 before latency", {25'b0, domPwr}, 32'h03);
    tick(1);
    check("R2 at latency", {25'b0, domPwr}, 32'h07);
    rd(8'h8C, v); check("R6 done not yet", v, 32'h0);
    tick(1);
    rd(8'h8C, v); check("R6 done stat", v, 32'h1);
    rd(8'h88, v); check("R6 done evt", v, 32'h1);
    clearAll();
    rd(8'h8C, v); check("R9 cleared", v, 32'h0);

    // R3 down
    wr(8'h10, 32'h04);
    seqDn();
    tick(LAT + 2);
    check("R3 down", {25'b0, domPwr}, 32'h03);
    rd(8'h8C, v); check("R3 done", v, 32'h1);
    clearAll();

    // R4 bad byte mid-sequence, then unlock byte without restart
    wr(8'h0C, 32'h08);
    wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'h33);
    rd(8'h8C, v); check("R4 fail stat", v, 32'h4);
    rd(8'h88, v); check("R4 fail evt", v, 32'h4);
    wr(8'h44, 32'h50);
    tick(LAT + 2);
    check("R4 no change", {25'b0, domPwr}, 32'h03);
    rd(8'h8C, v); check("R4 second fail only", v, 32'h4);
    check("R8 masked irq", {31'b0, irq}, 32'h0);
    clearAll();

    // R5 restart mid-sequence
    wr(8'h44, 32'hFF); wr(8'h44, 32'h05); seqUp();
    tick(LAT + 2);
    check("R5 restart works", {25'b0, domPwr}, 32'h0B);
    rd(8'h8C, v); check("R5 no failure", v, 32'h1);
    clearAll();

    // R6 + R9: already-on domain, done coincides with a clear of bit 0
    seqUp();
    rd(8'h8C, v); check("R6 immediate not yet", v, 32'h0);
    wr(8'h8C, 32'h1);
    rd(8'h8C, v); check("R9 set wins over clear", v, 32'h1);
    wr(8'h8C, 32'h1);
    rd(8'h8C, v); check("R9 clear stat", v, 32'h0);
    rd(8'h88, v); check("R9 evt independent", v, 32'h1);
    wr(8'h88, 32'h1);
    rd(8'h88, v); check("R9 clear evt", v, 32'h0);

    // R7 unlock while busy
    wr(8'h0C, 32'h10); wr(8'h10, 32'h01);
    seqUp(); seqDn();
    rd(8'h8C, v); check("R7 busy reject", v & 32'h8, 32'h8);
    tick(LAT + 2);
    check("R7 first transition only", {25'b0, domPwr}, 32'h1B);
    rd(8'h8C, v); check("R7 stat", v, 32'h9);

    // R8 mask and hold
    check("R8 all masked", {31'b0, irq}, 32'h0);
    wr(8'h48, 32'h1F7);
    check("R8 unmasked", {31'b0, irq}, 32'h1);
    wr(8'h8C, 32'h1);
    check("R8 held", {31'b0, irq}, 32'h1);
    wr(8'h8C, 32'h8);
    check("R8 cleared", {31'b0, irq}, 32'h0);
    wr(8'h48, 32'h1FF);
    clearAll();
    expPwr = 7'h1B;

    // R2/R3 sweep over every selection pattern
    for (int m = 0; m < 128; m++) begin
      logic [6:0] dm;
      dm = 7'((m * 37 + 11) & 127);
      wr(8'h0C, 32'(m));
      seqUp();
      tick(LAT + 2);
      expPwr = expPwr | 7'(m);
      check("R2 sweep up", {25'b0, domPwr}, {25'b0, expPwr});
      rd(8'h8C, v); check("R6 sweep done", v, 32'h1);
      clearAll();
      wr(8'h10, 32'(dm));
      seqDn();
      tick(LAT + 2);
      expPwr = expPwr & ~dm;
      rd(8'h80, v); check("R3 sweep down", v, {25'b0, expPwr});
      clearAll();
    end

    finishRun();
  end

endmodule